// File: doc/BRIEF.md
# Quad DAC Serial Load Controller

This block sits on the host side of a four-channel, 12-bit serial DAC. A client presents a channel select and a 12-bit output code and pulses a start request while ready is high. The controller then builds one 16-bit word and shifts it out over a three-wire serial link. Chip select stays low across the whole word. The serial clock idles high, and data moves on falling clock edges so that it is stable when the DAC samples it at each rising edge. After the word ends, the controller releases chip select with the clock already high. It then pulses an active-low load strobe, which moves the shifted word into the DAC's output register.

Serial clock half-periods, chip-select setup and hold, and the width of the load pulse are all counted in system clocks and set by parameters. A separate clear request drives an active-low clear line to the DAC for a parameter number of cycles. The clear line works independently of the serial state machine: a frame that is in flight finishes unchanged.

The sequencer has seven states: IDLE, SETUP, CLK_LOW, CLK_HIGH, HOLD, DESELECT and LOAD. Its transitions are:
- IDLE to SETUP when start is seen.
- SETUP to CLK_LOW when the setup count expires.
- CLK_LOW to CLK_HIGH when the half-period expires.
- CLK_HIGH to CLK_LOW when the half-period expires and bits remain.
- CLK_HIGH to HOLD when the half-period expires after the sixteenth bit.
- HOLD to DESELECT when the hold count expires.
- DESELECT to LOAD after one cycle.
- LOAD to IDLE when the load width expires.

Top module: `qdac_load_ctrl`

## Requirements
- R1: Out of reset, chip select, load strobe and clear are high (inactive), the serial clock is high, serial data is 0 and ready is 1.
- R2: While chip select is low, serial data changes only when the serial clock falls, so the data is stable at every rising edge.
- R3: The word is sent MSB first. Bits 15:14 hold the channel (A=0, B=1, C=2, D=3), bits 13:12 hold the CTRL_CODE parameter, and bits 11:0 hold the code.
- R4: Exactly 16 rising serial clock edges occur while chip select is low, and chip select does not rise between the two bytes.
- R5: Chip select falls exactly CS_SETUP system clocks before the first falling serial clock edge.
- R6: The serial clock is high when chip select rises, and the last rising edge comes exactly DIV+CS_HOLD system clocks before chip select rises.
- R7: The load strobe falls one system clock after chip select rises and stays low for exactly LD_WIDTH system clocks. It is never low while chip select is low.
- R8: Ready is high only when no frame or load pulse is active. A start request is taken only while ready is high. A start request made during a frame has no effect: no extra frame follows and the current word is unchanged. Ready returns in the cycle the load strobe rises.
- R9: A clear request makes clear go low in the next cycle. Clear stays low for CLR_WIDTH system clocks after the last request, whatever the serial sequencer is doing, and a frame in progress completes with its word intact.
- R10: Inside a frame, every low phase of the serial clock and every high phase between two low phases lasts exactly DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to send one word |
| chan_i | input | 2 | Channel select, A=0 to D=3 |
| code_i | input | 12 | Output code for the selected channel |
| clr_req_i | input | 1 | Request for a clear pulse |
| ready_o | output | 1 | Controller idle, start accepted |
| dac_cs_n_o | output | 1 | Active-low chip select |
| dac_sclk_o | output | 1 | Serial clock, idle high |
| dac_sdi_o | output | 1 | Serial data to the DAC |
| dac_ld_n_o | output | 1 | Active-low load strobe |
| dac_clr_n_o | output | 1 | Active-low asynchronous clear to the DAC |

## Verification
The properties assume that the client holds chan_i and code_i steady only in the cycle start is accepted. They make no assumption about when start or clear requests arrive. They also assume reset lasts long enough to set the registered outputs to their idle values before any frame starts. The stimulus sends random channels and codes back to back and adds three kinds of directed disturbance: start requests fired in the middle of a frame, clear requests during frames and during idle, and overlapping clear requests. These cover the ignore and clear-independence cases without breaking those assumptions.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int CHAN_W = 2;
    localparam int CTRL_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_HOLD,
        ST_DESELECT,
        ST_LOAD
    } qdac_state_e;

    // Channel in the top two bits, control field next, code at the bottom.
    function automatic logic [WORD_W-1:0] build_word(
        input logic [CHAN_W-1:0] chan,
        input logic [CTRL_W-1:0] ctrl,
        input logic [CODE_W-1:0] code
    );
        return {chan, ctrl, code};
    endfunction

endpackage

// File: rtl/qdac_phase_timer.sv
module qdac_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/qdac_frame_shift.sv
module qdac_frame_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    input  logic         clear,
    output logic         msb,
    output logic         last
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bits_q <= '0;
        end else if (load) begin
            sr_q   <= load_word;
            bits_q <= '0;
        end else if (clear) begin
            sr_q   <= '0;
            bits_q <= '0;
        end else if (shift) begin
            sr_q   <= {sr_q[W-2:0], 1'b0};
            bits_q <= bits_q + 1'b1;
        end
    end

    assign msb  = sr_q[W-1];
    assign last = (bits_q == CW'(W - 1));

endmodule

// File: rtl/qdac_clr_stretch.sv
module qdac_clr_stretch #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic clr_n
);

    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          clr_n_q;

    always_comb begin
        if (req) begin
            cnt_d = CW'(WIDTH);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clr_n_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_d;
            clr_n_q <= (cnt_d == '0);
        end
    end

    assign clr_n = clr_n_q;

endmodule

// File: rtl/qdac_load_ctrl.sv
module qdac_load_ctrl
    import qdac_pkg::*;
#(
    parameter int         DIV       = 2,
    parameter int         CS_SETUP  = 2,
    parameter int         CS_HOLD   = 3,
    parameter int         LD_WIDTH  = 3,
    parameter int         CLR_WIDTH = 4,
    parameter logic [1:0] CTRL_CODE = 2'b10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  chan_i,
    input  logic [11:0] code_i,
    input  logic        clr_req_i,
    output logic        ready_o,
    output logic        dac_cs_n_o,
    output logic        dac_sclk_o,
    output logic        dac_sdi_o,
    output logic        dac_ld_n_o,
    output logic        dac_clr_n_o
);

    localparam int MAX_AB = (DIV > CS_SETUP) ? DIV : CS_SETUP;
    localparam int MAX_CD = (CS_HOLD > LD_WIDTH) ? CS_HOLD : LD_WIDTH;
    localparam int MAXV   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW     = $clog2(MAXV) + 1;

    qdac_state_e state_q, state_d;

    logic          tmr_done;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_clear, sh_msb, sh_last;

    logic cs_n_q, sclk_q, ld_n_q, ready_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)  state_d = ST_SETUP;
            ST_SETUP:    if (tmr_done) state_d = ST_CLK_LOW;
            ST_CLK_LOW:  if (tmr_done) state_d = ST_CLK_HIGH;
            ST_CLK_HIGH: if (tmr_done) state_d = sh_last ? ST_HOLD : ST_CLK_LOW;
            ST_HOLD:     if (tmr_done) state_d = ST_DESELECT;
            ST_DESELECT:               state_d = ST_LOAD;
            ST_LOAD:     if (tmr_done) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b1;
            ld_n_q  <= 1'b1;
            ready_q <= 1'b1;
        end else begin
            cs_n_q  <= !(state_d inside {ST_SETUP, ST_CLK_LOW, ST_CLK_HIGH, ST_HOLD});
            sclk_q  <= (state_d != ST_CLK_LOW);
            ld_n_q  <= (state_d != ST_LOAD);
            ready_q <= (state_d == ST_IDLE);
        end
    end

    // Timer reload on every state change, sized by the state entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:                tmr_val = TW'(CS_SETUP - 1);
            ST_CLK_LOW, ST_CLK_HIGH: tmr_val = TW'(DIV - 1);
            ST_HOLD:                 tmr_val = TW'(CS_HOLD - 1);
            ST_LOAD:                 tmr_val = TW'(LD_WIDTH - 1);
            default:                 tmr_val = '0;
        endcase
    end

    assign sh_load  = (state_q == ST_IDLE) && start_i;
    assign sh_shift = (state_q == ST_CLK_HIGH) && tmr_done && !sh_last;
    assign sh_clear = (state_d == ST_DESELECT) && (state_q == ST_HOLD);

    qdac_phase_timer #(
        .TW(TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    qdac_frame_shift #(
        .W(WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (build_word(chan_i, CTRL_CODE, code_i)),
        .shift     (sh_shift),
        .clear     (sh_clear),
        .msb       (sh_msb),
        .last      (sh_last)
    );

    qdac_clr_stretch #(
        .WIDTH(CLR_WIDTH)
    ) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (clr_req_i),
        .clr_n (dac_clr_n_o)
    );

    assign ready_o    = ready_q;
    assign dac_cs_n_o = cs_n_q;
    assign dac_sclk_o = sclk_q;
    assign dac_sdi_o  = sh_msb;
    assign dac_ld_n_o = ld_n_q;

endmodule

// File: rtl/qdac_load_chk.sv
module qdac_load_chk (
    input logic clk,
    input logic rst_n,
    input logic ready_o,
    input logic dac_cs_n_o,
    input logic dac_sclk_o,
    input logic dac_sdi_o,
    input logic dac_ld_n_o,
    input logic clr_req_i,
    input logic dac_clr_n_o
);

    logic [4:0] edges_q;
    logic       sclk_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q     <= '0;
            sclk_prev_q <= 1'b1;
        end else begin
            sclk_prev_q <= dac_sclk_o;
            if (dac_cs_n_o) begin
                edges_q <= '0;
            end else if (dac_sclk_o && !sclk_prev_q) begin
                edges_q <= edges_q + 1'b1;
            end
        end
    end

    a_r2_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n_o && $rose(dac_sclk_o)) |-> $stable(dac_sdi_o));

    a_r4_edge_cap: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= 5'd16);

    a_r4_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n_o) |-> (edges_q == 5'd16));

    a_r6_clk_high_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n_o) |-> (dac_sclk_o && $past(dac_sclk_o)));

    a_r7_load_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n_o |-> dac_cs_n_o);

    a_r7_load_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ld_n_o) |-> $past(dac_cs_n_o));

    a_r8_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (dac_cs_n_o && dac_ld_n_o));

    a_r9_clear_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> !dac_clr_n_o);

endmodule

bind qdac_load_ctrl qdac_load_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_o     (ready_o),
    .dac_cs_n_o  (dac_cs_n_o),
    .dac_sclk_o  (dac_sclk_o),
    .dac_sdi_o   (dac_sdi_o),
    .dac_ld_n_o  (dac_ld_n_o),
    .clr_req_i   (clr_req_i),
    .dac_clr_n_o (dac_clr_n_o)
);

// File: tb/sim_qdac_load_ctrl.sv
`timescale 1ns/1ps
module sim_qdac_load_ctrl;

    localparam int         DIV  = 2;
    localparam int         SETUP = 2;
    localparam int         HOLD = 3;
    localparam int         LDW  = 3;
    localparam int         CLRW = 4;
    localparam logic [1:0] CTRL = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  chan = '0;
    logic [11:0] code = '0;
    logic        clr_req = 1'b0;
    logic        ready, cs_n, sclk, sdi, ld_n, clr_n;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    qdac_load_ctrl #(
        .DIV(DIV), .CS_SETUP(SETUP), .CS_HOLD(HOLD),
        .LD_WIDTH(LDW), .CLR_WIDTH(CLRW), .CTRL_CODE(CTRL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan), .code_i(code),
        .clr_req_i(clr_req), .ready_o(ready), .dac_cs_n_o(cs_n), .dac_sclk_o(sclk),
        .dac_sdi_o(sdi), .dac_ld_n_o(ld_n), .dac_clr_n_o(clr_n)
    );

    function automatic logic [15:0] expect_word(input logic [1:0] c, input logic [11:0] d);
        return {c, CTRL, d};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor state
    logic [15:0] exp_word = '0;
    int          exp_clr_w = CLRW;
    int          frames = 0;
    logic        pcs = 1'b1, psclk = 1'b1, pld = 1'b1, pclr = 1'b1, psdi = 1'b0;
    logic [15:0] word = '0;
    int edges = 0, run = 0, since_cs = 0, gap = 0, lw = 0, cw = 0;
    bit first_fall = 1'b0, mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (pcs && !cs_n) begin
                frames++;
                edges = 0; word = '0; since_cs = 0; first_fall = 1'b0; run = 0;
                check(!ready, "R8 ready low in frame", ready, 0);
            end else if (!cs_n) begin
                since_cs++;
                if (sdi != psdi)
                    check(psclk && !sclk, "R2 data moves on falling edge", sclk, 0);
                if (sclk != psclk) begin
                    if (sclk) begin
                        check(run == DIV, "R10 low phase", run, DIV);
                        word = {word[14:0], sdi};
                        edges++;
                    end else if (!first_fall) begin
                        first_fall = 1'b1;
                        check(since_cs == SETUP, "R5 cs setup", since_cs, SETUP);
                    end else begin
                        check(run == DIV, "R10 high phase", run, DIV);
                    end
                    run = 1;
                end else begin
                    run++;
                end
            end
            if (!pcs && cs_n) begin
                check(sclk == 1'b1, "R6 clock high at release", sclk, 1);
                check(run == DIV + HOLD, "R6 hold time", run, DIV + HOLD);
                check(edges == 16, "R4 rising edge count", edges, 16);
                check(word == exp_word, "R3 word content", word, exp_word);
                gap = 0;
            end else if (cs_n) begin
                gap++;
            end
            if (pld && !ld_n) begin
                check(gap == 1, "R7 load after release", gap, 1);
                lw = 1;
            end else if (!pld && ld_n) begin
                check(lw == LDW, "R7 load width", lw, LDW);
                check(ready == 1'b1, "R8 ready after load", ready, 1);
            end else if (!ld_n) begin
                lw++;
            end
            if (pclr && !clr_n) begin
                cw = 1;
            end else if (!pclr && clr_n) begin
                check(cw == exp_clr_w, "R9 clear width", cw, exp_clr_w);
            end else if (!clr_n) begin
                cw++;
            end
        end
        pcs = cs_n; psclk = sclk; pld = ld_n; pclr = clr_n; psdi = sdi;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send(input logic [1:0] c, input logic [11:0] d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        chan = c; code = d; start = 1'b1;
        exp_word = expect_word(c, d);
        @(negedge clk);
        start = 1'b0;
        chan = ~c; code = ~d;
        while (!ready) @(negedge clk);
    endtask

    initial begin
        int f0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(cs_n && sclk && ld_n && clr_n && ready && !sdi, "R1 reset state",
              {cs_n, sclk, ld_n, clr_n, ready, sdi}, 6'b111110);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        check(cs_n && sclk && ld_n && clr_n && ready && !sdi, "R1 idle after reset",
              {cs_n, sclk, ld_n, clr_n, ready, sdi}, 6'b111110);

        // Directed corner codes on each channel
        send(2'd0, 12'h000);
        send(2'd3, 12'hFFF);
        send(2'd1, 12'hA5A);
        send(2'd2, 12'h5A5);

        // Random frames
        for (int i = 0; i < 20; i++) begin
            send(2'($urandom_range(0, 3)), 12'($urandom_range(0, 4095)));
            if ($urandom_range(0, 1) == 1) repeat ($urandom_range(0, 5)) @(negedge clk);
        end
        check(frames == 24, "R8 frame count", frames, 24);

        // Start during a frame is ignored (R8)
        f0 = frames;
        @(negedge clk);
        chan = 2'd1; code = 12'h3C3; start = 1'b1;
        exp_word = expect_word(2'd1, 12'h3C3);
        @(negedge clk);
        chan = 2'd2; code = 12'h0F0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0;
        while (!ready) @(negedge clk);
        repeat (12) @(negedge clk);
        check(frames == f0 + 1, "R8 mid-frame start ignored", frames, f0 + 1);
        check(cs_n == 1'b1 && ready, "R8 idle after ignored start", cs_n, 1);

        // Clear during a frame (R9)
        @(negedge clk);
        chan = 2'd3; code = 12'h123; start = 1'b1;
        exp_word = expect_word(2'd3, 12'h123);
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        check(clr_n == 1'b0, "R9 clear asserted mid-frame", clr_n, 0);
        check(cs_n == 1'b0, "R9 frame continues", cs_n, 0);
        while (!ready) @(negedge clk);
        repeat (4) @(negedge clk);

        // Overlapping clear requests in idle (R9)
        exp_clr_w = CLRW + 2;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        repeat (CLRW + 4) @(negedge clk);
        check(clr_n == 1'b1 && cs_n, "R9 clear released, no frame", clr_n, 1);
        exp_clr_w = CLRW;

        send(2'd0, 12'h800);
        repeat (5) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule